// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a set of level-sensitive interrupt lines, 64 by default, and presents one interrupt request to a processor. The request is an interrupt level plus a vector number. Each source has an 8-bit priority byte. Writing a nonzero byte turns the source on, and writing zero turns it off. Three wide registers decide which sources take part. A pending register follows the input lines. A software force register can raise a source without its line. A mask register holds back chosen sources. Among the sources that take part, the one with the largest priority byte wins. When several sources share that byte, the highest-numbered one wins.

Software uses an 8-bit byte-offset register bus. Each wide register is seen as two 32-bit halves. The priority bytes sit in a contiguous window, one byte per offset. A read-only acknowledge location returns the vector currently presented. Reads are combinational from the offset. Writes take effect at the clock edge. A write to an offset with no writable register produces a one-cycle error strobe. The arbiter is built either as a balanced comparison tree or as a linear scan, chosen by a parameter. Both give the same result.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source takes part only when (pending OR force) AND enable AND NOT mask is 1 for its bit.
- R2: The winner is the taking-part source with the largest priority byte, compared as an unsigned 8-bit value. On a tie, the higher source index wins.
- R3: The vector output is the winner's index plus 64. With no source taking part, the vector is 24 and the level is 0.
- R4: The level output equals the winner's priority byte.
- R5: A write to offset 0x40+n stores byte n. It sets enable bit n when the byte is nonzero and clears it when the byte is zero.
- R6: The read map is as follows. 0x00 and 0x04 give pending bits 63..32 and 31..0. 0x08 and 0x0C give the mask halves. 0x10 and 0x14 give the force halves. 0x40+n gives byte n, zero-extended. 0xE0 gives the current vector. Every other offset reads 0.
- R7: Writes to 0x00 and 0x04 are accepted without error but change nothing. Each mask half (0x08, 0x0C) and each force half (0x10, 0x14) is written alone, leaving the other half unchanged.
- R8: After reset, the mask is all ones. Pending, force, enable and all priority bytes are zero. The outputs are level 0 and vector 24.
- R9: Pending bit n is the level of input n sampled at each clock edge. It clears when the line is low, with no latching.
- R10: The level and vector outputs are registered from the register state. An input change sampled at edge k, or a write taken at edge k, shows at the outputs after edge k+1.
- R11: A write to any other offset, including 0xE0 to 0xE7, raises the error output for exactly the one cycle after the write edge and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Level-sensitive interrupt lines |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| bus_err_o | output | 1 | One-cycle strobe after a write to an unwritable offset |
| irq_level_o | output | PRIO_W | Priority level of the winning source, 0 when idle |
| irq_vector_o | output | VEC_W | Vector of the winning source, idle vector when none |

## Verification
The bench builds two copies with the default 64 sources, 8-bit priority bytes, vector base 64 and idle vector 24. One copy uses the tree arbiter and the other uses the linear scan. Both are compared against the same expected values. With all 64 sources, both halves of every wide register are reachable. A force bit in the upper half (source 40) and mask edits to one half only can therefore be observed. Priority bytes above 127 exercise the unsigned compare, and equal bytes on sources 5 and 10 exercise the tie rule.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int unsigned BUS_AW = 8;
   typedef logic [BUS_AW-1:0] bus_addr_t;

   localparam bus_addr_t OFS_PEND_HI  = 8'h00;
   localparam bus_addr_t OFS_PEND_LO  = 8'h04;
   localparam bus_addr_t OFS_MASK_HI  = 8'h08;
   localparam bus_addr_t OFS_MASK_LO  = 8'h0C;
   localparam bus_addr_t OFS_FORCE_HI = 8'h10;
   localparam bus_addr_t OFS_FORCE_LO = 8'h14;
   localparam bus_addr_t OFS_PRIO_BASE = 8'h40;
   localparam bus_addr_t OFS_SWACK    = 8'hE0;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_PEND_HI,
      SEL_PEND_LO,
      SEL_MASK_HI,
      SEL_MASK_LO,
      SEL_FORCE_HI,
      SEL_FORCE_LO,
      SEL_PRIO,
      SEL_SWACK
   } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import prio_irq_pkg::*;
#(
   parameter int N_SRC = 64,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  bus_addr_t        addr_i,
   output reg_sel_e         sel_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [31:0] PRIO_LO = 32'(OFS_PRIO_BASE);
   localparam logic [31:0] PRIO_HI = 32'(OFS_PRIO_BASE) + 32'(N_SRC);

   bus_addr_t rel;
   assign rel = addr_i - OFS_PRIO_BASE;

   always_comb begin
      sel_o = SEL_NONE;
      idx_o = '0;
      if (32'(addr_i) >= PRIO_LO && 32'(addr_i) < PRIO_HI) begin
         sel_o = SEL_PRIO;
         idx_o = rel[IDX_W-1:0];
      end else begin
         case (addr_i)
            OFS_PEND_HI:  sel_o = SEL_PEND_HI;
            OFS_PEND_LO:  sel_o = SEL_PEND_LO;
            OFS_MASK_HI:  sel_o = SEL_MASK_HI;
            OFS_MASK_LO:  sel_o = SEL_MASK_LO;
            OFS_FORCE_HI: sel_o = SEL_FORCE_HI;
            OFS_FORCE_LO: sel_o = SEL_FORCE_LO;
            OFS_SWACK:    sel_o = SEL_SWACK;
            default:      sel_o = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
   import prio_irq_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int DATA_W = 32,
   parameter int PRIO_W = 8,
   parameter int VEC_W  = 8,
   localparam int IDX_W  = $clog2(N_SRC),
   localparam int WIDE_W = 2 * DATA_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        irq_i,
   input  logic                    wr_i,
   input  bus_addr_t               addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic [VEC_W-1:0]        vector_i,
   output logic [DATA_W-1:0]       rdata_o,
   output logic                    err_o,
   output logic [N_SRC-1:0]        active_o,
   output logic [N_SRC*PRIO_W-1:0] prio_flat_o
);

   if (DATA_W != 32) begin : g_bad_dw
      $error("irq_regbank: DATA_W must be 32");
   end
   if (N_SRC < 2 || N_SRC > WIDE_W) begin : g_bad_nsrc
      $error("irq_regbank: N_SRC must lie in 2..64");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_pw
      $error("irq_regbank: PRIO_W must lie in 1..8");
   end

   reg_sel_e         sel;
   logic [IDX_W-1:0] idx;

   irq_addr_decode #(.N_SRC(N_SRC)) u_dec (
      .addr_i (addr_i),
      .sel_o  (sel),
      .idx_o  (idx)
   );

   logic [N_SRC-1:0]  pend_q, force_q, mask_q, en_q;
   logic [PRIO_W-1:0] prio_q [N_SRC];
   logic              err_q;

   logic [WIDE_W-1:0] pend_w, force_w, mask_w;
   assign pend_w  = WIDE_W'(pend_q);
   assign force_w = WIDE_W'(force_q);
   assign mask_w  = WIDE_W'(mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         force_q <= '0;
         mask_q  <= '1;
         en_q    <= '0;
         err_q   <= 1'b0;
         for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
      end else begin
         pend_q <= irq_i;
         err_q  <= wr_i && (sel == SEL_NONE || sel == SEL_SWACK);
         if (wr_i) begin
            case (sel)
               SEL_MASK_HI:  mask_q  <= N_SRC'({wdata_i, mask_w[DATA_W-1:0]});
               SEL_MASK_LO:  mask_q  <= N_SRC'({mask_w[WIDE_W-1:DATA_W], wdata_i});
               SEL_FORCE_HI: force_q <= N_SRC'({wdata_i, force_w[DATA_W-1:0]});
               SEL_FORCE_LO: force_q <= N_SRC'({force_w[WIDE_W-1:DATA_W], wdata_i});
               SEL_PRIO: begin
                  prio_q[idx] <= wdata_i[PRIO_W-1:0];
                  en_q[idx]   <= |wdata_i[PRIO_W-1:0];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (sel)
         SEL_PEND_HI:  rdata_o = pend_w[WIDE_W-1:DATA_W];
         SEL_PEND_LO:  rdata_o = pend_w[DATA_W-1:0];
         SEL_MASK_HI:  rdata_o = mask_w[WIDE_W-1:DATA_W];
         SEL_MASK_LO:  rdata_o = mask_w[DATA_W-1:0];
         SEL_FORCE_HI: rdata_o = force_w[WIDE_W-1:DATA_W];
         SEL_FORCE_LO: rdata_o = force_w[DATA_W-1:0];
         SEL_PRIO:     rdata_o = DATA_W'(prio_q[idx]);
         SEL_SWACK:    rdata_o = DATA_W'(vector_i);
         default:      rdata_o = '0;
      endcase
   end

   assign err_o    = err_q;
   assign active_o = (pend_q | force_q) & en_q & ~mask_q;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign prio_flat_o[g*PRIO_W +: PRIO_W] = prio_q[g];

      // R5: enable bit always agrees with the stored byte being nonzero
      p_en_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
         en_q[g] == (prio_q[g] != '0));
   end

   // R9: pending follows the line sampled one edge earlier
   p_pend_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> pend_q == $past(irq_i));

   // R7: a write to the upper mask half leaves the lower half alone
   p_mask_lo_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_i && sel == SEL_MASK_HI) |-> mask_w[DATA_W-1:0] == $past(mask_w[DATA_W-1:0]));

   // R11: the error strobe only follows a write
   p_err_after_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(wr_i));

   // R11: a rejected write leaves mask and force untouched
   p_err_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (mask_q == $past(mask_q) && force_q == $past(force_q) && en_q == $past(en_q)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N_SRC    = 64,
   parameter int PRIO_W   = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64,
   parameter int VEC_IDLE = 24,
   parameter bit ARB_TREE = 1'b1,
   localparam int IDX_W = $clog2(N_SRC),
   localparam int NP    = 1 << IDX_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        active_i,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat_i,
   output logic [PRIO_W-1:0]       level_o,
   output logic [VEC_W-1:0]        vector_o
);

   if (VEC_BASE + N_SRC > (1 << VEC_W) || VEC_IDLE >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_arbiter: vectors do not fit VEC_W");
   end

   logic              win_v;
   logic [PRIO_W-1:0] win_p;
   logic [IDX_W-1:0]  win_i;

   if (ARB_TREE) begin : g_tree
      logic              nd_v [2*NP];
      logic [PRIO_W-1:0] nd_p [2*NP];
      logic [IDX_W-1:0]  nd_i [2*NP];

      assign nd_v[0] = 1'b0;
      assign nd_p[0] = '0;
      assign nd_i[0] = '0;

      for (genvar g = 0; g < NP; g++) begin : g_leaf
         if (g < N_SRC) begin : g_real
            assign nd_v[NP+g] = active_i[g];
            assign nd_p[NP+g] = prio_flat_i[g*PRIO_W +: PRIO_W];
         end else begin : g_pad
            assign nd_v[NP+g] = 1'b0;
            assign nd_p[NP+g] = '0;
         end
         assign nd_i[NP+g] = IDX_W'(g);
      end

      for (genvar n = 1; n < NP; n++) begin : g_node
         logic take_hi;
         assign take_hi = nd_v[2*n+1] && (!nd_v[2*n] || nd_p[2*n+1] >= nd_p[2*n]);
         assign nd_v[n] = nd_v[2*n] | nd_v[2*n+1];
         assign nd_p[n] = take_hi ? nd_p[2*n+1] : nd_p[2*n];
         assign nd_i[n] = take_hi ? nd_i[2*n+1] : nd_i[2*n];
      end

      assign win_v = nd_v[1];
      assign win_p = nd_p[1];
      assign win_i = nd_i[1];
   end else begin : g_scan
      always_comb begin
         win_v = 1'b0;
         win_p = '0;
         win_i = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (active_i[i] && (!win_v || prio_flat_i[i*PRIO_W +: PRIO_W] >= win_p)) begin
               win_v = 1'b1;
               win_p = prio_flat_i[i*PRIO_W +: PRIO_W];
               win_i = IDX_W'(i);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o  <= '0;
         vector_o <= VEC_W'(VEC_IDLE);
      end else begin
         level_o  <= win_v ? win_p : '0;
         vector_o <= win_v ? VEC_W'(VEC_BASE) + VEC_W'(win_i) : VEC_W'(VEC_IDLE);
      end
   end

   logic [VEC_W-1:0] vec_off;
   logic [IDX_W-1:0] out_idx;
   assign vec_off = vector_o - VEC_W'(VEC_BASE);
   assign out_idx = vec_off[IDX_W-1:0];

   // R3: nothing taking part gives the idle pair
   p_idle_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(|active_i) |-> (vector_o == VEC_W'(VEC_IDLE) && level_o == '0));

   // R2: a presented request names a source that was taking part
   p_win_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != '0) |-> ((($past(active_i) >> out_idx) & N_SRC'(1)) != '0));

   // R4: any source taking part yields a nonzero level
   p_level_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|active_i) |-> level_o != '0);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC    = 64,
   parameter int DATA_W   = 32,
   parameter int PRIO_W   = 8,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64,
   parameter int VEC_IDLE = 24,
   parameter bit ARB_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_i,
   input  logic              bus_wr_i,
   input  logic [7:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              bus_err_o,
   output logic [PRIO_W-1:0] irq_level_o,
   output logic [VEC_W-1:0]  irq_vector_o
);

   logic [N_SRC-1:0]        active;
   logic [N_SRC*PRIO_W-1:0] prio_flat;

   irq_regbank #(
      .N_SRC  (N_SRC),
      .DATA_W (DATA_W),
      .PRIO_W (PRIO_W),
      .VEC_W  (VEC_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_i       (irq_i),
      .wr_i        (bus_wr_i),
      .addr_i      (bus_addr_i),
      .wdata_i     (bus_wdata_i),
      .vector_i    (irq_vector_o),
      .rdata_o     (bus_rdata_o),
      .err_o       (bus_err_o),
      .active_o    (active),
      .prio_flat_o (prio_flat)
   );

   irq_arbiter #(
      .N_SRC    (N_SRC),
      .PRIO_W   (PRIO_W),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_IDLE (VEC_IDLE),
      .ARB_TREE (ARB_TREE)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (active),
      .prio_flat_i (prio_flat),
      .level_o     (irq_level_o),
      .vector_o    (irq_vector_o)
   );

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq = '0;
   logic        wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;

   logic [31:0] rdata_t, rdata_l;
   logic        err_t, err_l;
   logic [7:0]  lvl_t, lvl_l, vec_t, vec_l;

   always #4 clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata_t), .bus_err_o(err_t),
      .irq_level_o(lvl_t), .irq_vector_o(vec_t));

   prio_irq_ctrl #(.ARB_TREE(1'b0)) dut_lin_i (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata_l), .bus_err_o(err_l),
      .irq_level_o(lvl_l), .irq_vector_o(vec_l));

   typedef struct {
      logic [7:0] lvl;
      logic [7:0] vec;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   // monitor: pops one expected item per falling edge and compares both copies
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (lvl_t !== e.lvl || vec_t !== e.vec || lvl_l !== e.lvl || vec_l !== e.vec) begin
               n_bad++;
               $display("FAIL %s: level/vector tree=%0d/%0d scan=%0d/%0d expected=%0d/%0d",
                        e.tag, lvl_t, vec_t, lvl_l, vec_l, e.lvl, e.vec);
            end
         end
      end
   end

   task automatic chk_out(input logic [7:0] l, input logic [7:0] v, input string tag);
      @(posedge clk);
      sb_q.push_back('{lvl: l, vec: v, tag: tag});
      @(negedge clk);
      #1;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #1;
      n_chk++;
      if (rdata_t !== exp || rdata_l !== exp) begin
         n_bad++;
         $display("FAIL %s: read 0x%02h tree=0x%08h scan=0x%08h expected=0x%08h",
                  tag, a, rdata_t, rdata_l, exp);
      end
   endtask

   task automatic err_chk(input logic exp, input string tag);
      n_chk++;
      if (err_t !== exp || err_l !== exp) begin
         n_bad++;
         $display("FAIL %s: err tree=%0b scan=%0b expected=%0b", tag, err_t, err_l, exp);
      end
   endtask

   task automatic set_irq(input int n, input logic v);
      @(negedge clk);
      irq[n] = v;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (R10): actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state
      chk_out(8'd0, 8'd24, "R8 reset outputs");
      rd_chk(8'h08, 32'hFFFF_FFFF, "R8 mask hi");
      rd_chk(8'h0C, 32'hFFFF_FFFF, "R8 mask lo");
      rd_chk(8'h04, 32'h0, "R8 pending lo");
      rd_chk(8'h10, 32'h0, "R8 force hi");
      rd_chk(8'h45, 32'h0, "R8 priority byte");
      rd_chk(8'hE0, 32'd24, "R8 ack vector");

      // R1 masked source stays out
      bus_write(8'h45, 32'd3);
      set_irq(5, 1'b1);
      @(posedge clk);
      chk_out(8'd0, 8'd24, "R1 masked source");
      bus_write(8'h0C, 32'h0);
      bus_write(8'h08, 32'h0);
      chk_out(8'd3, 8'd69, "R3 R4 single source");
      rd_chk(8'h04, 32'h0000_0020, "R9 R6 pending lo");

      // R10 latency and R2 tie
      bus_write(8'h4A, 32'd3);
      chk_out(8'd3, 8'd69, "R1 enabled but not pending");
      set_irq(10, 1'b1);
      chk_out(8'd3, 8'd69, "R10 output one edge later");
      chk_out(8'd3, 8'd74, "R2 tie to higher index, R10");

      // R2 unsigned compare above 127
      bus_write(8'h43, 32'hC8);
      set_irq(3, 1'b1);
      chk_out(8'd3, 8'd74, "R10 before update");
      chk_out(8'd200, 8'd67, "R2 unsigned byte R4");

      // R5 zero byte disables
      bus_write(8'h43, 32'h0);
      chk_out(8'd3, 8'd74, "R5 zero byte disables");
      rd_chk(8'h43, 32'h0, "R5 byte reads zero");

      // R9 line low clears pending
      set_irq(10, 1'b0);
      @(posedge clk);
      chk_out(8'd3, 8'd69, "R9 pending follows level");

      // R1 force in upper half (source 40)
      bus_write(8'h68, 32'd7);
      bus_write(8'h10, 32'h0000_0100);
      chk_out(8'd7, 8'd104, "R1 forced source");
      rd_chk(8'h10, 32'h0000_0100, "R6 force hi");
      rd_chk(8'h14, 32'h0, "R7 force lo untouched");

      // R7 mask half alone
      bus_write(8'h08, 32'h0000_0100);
      chk_out(8'd3, 8'd69, "R7 mask hi masks source 40");
      rd_chk(8'h0C, 32'h0, "R7 mask lo untouched");
      rd_chk(8'h08, 32'h0000_0100, "R6 mask hi");

      // R7 pending write ignored
      bus_write(8'h04, 32'hFFFF_FFFF);
      err_chk(1'b0, "R7 pending write no error");
      rd_chk(8'h04, 32'h0000_0028, "R7 pending unchanged");

      // R11 unmapped write
      bus_write(8'hE3, 32'h5);
      err_chk(1'b1, "R11 error strobe");
      @(negedge clk);
      err_chk(1'b0, "R11 strobe one cycle");
      rd_chk(8'h08, 32'h0000_0100, "R11 mask hi unchanged");
      rd_chk(8'h0C, 32'h0, "R11 mask lo unchanged");
      chk_out(8'd3, 8'd69, "R11 outputs unchanged");

      // R6 other reads
      rd_chk(8'hE0, 32'd69, "R6 ack returns vector");
      rd_chk(8'h20, 32'h0, "R6 unmapped read");
      rd_chk(8'h7F, 32'h0, "R6 unwritten byte");

      // R3 back to idle
      bus_write(8'h0C, 32'h0000_0020);
      chk_out(8'd0, 8'd24, "R3 idle after masking");
      rd_chk(8'hE0, 32'd24, "R3 ack idle vector");

      done = 1'b1;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule